// File: doc/BRIEF.md
# Host Burst FIFO Pair

This block sits between a host data port and an internal memory engine. It holds two 8-entry, 32-bit FIFOs. Host writes go into the write FIFO. The memory side drains that FIFO in 4-word bursts to an address that advances word by word. Host reads are served from the read FIFO. A pulse on `rd_start` opens a sequential read session at `rd_addr`. The memory side then prefetches two 4-word bursts, one right after the other, and requests another burst each time four words of room free up. A single `host_ready` output stalls the host when it pushes into a full write FIFO or pops from an empty read FIFO.

The memory side is one state machine with three states: IDLE, WBURST (a write burst) and RBURST (a read burst). A decision point is any cycle in IDLE, or the cycle in which the last beat of a burst is granted. At a decision point the machine takes one of three transitions. It goes to WBURST when a write burst is due. Otherwise it goes to RBURST when a read burst is due. Otherwise it goes to IDLE. So a write burst wins over a read burst, and a read burst can follow a read burst with no idle cycle between them.

`wflush` drains a remainder of fewer than four words as a shorter burst. `rflush` lets an in-flight read burst finish, then discards the read FIFO and ends the session. A new `rd_start` is handled the same way, except that it opens a new session afterwards.

Top module: `host_burst_fifos`

## Requirements
- R1: After reset, `host_ready` is 1 and `mem_req` is 0. Both FIFOs are empty.
- R2: A write burst does not start while the write FIFO holds fewer than 4 words. Once it holds 4, a burst with `mem_we`=1 transfers 4 words in push order. One word moves in each cycle where `mem_req` and `mem_gnt` are both 1.
- R3: The first write burst targets the word address latched by `wr_start`/`wr_addr`. Each beat adds 1 to the address, and the next burst continues directly after the last word written.
- R4: While the write FIFO holds 8 words, a cycle with `hw_valid`=1 has `host_ready`=0 and the word is not taken. The word is taken once space frees up.
- R5: After a `wflush` pulse, a remainder of fewer than 4 words is written as one shorter burst at the next addresses. Without a flush, such a remainder stays in the FIFO.
- R6: After a `rd_start` pulse, exactly 8 words are read from `rd_addr`, `rd_addr`+1, … `rd_addr`+7. Reading then stops while the host pops nothing.
- R7: With `mem_gnt` held at 1, the second prefetch burst begins in the cycle right after the last beat of the first burst, so all 8 read beats fall in 8 consecutive cycles.
- R8: A cycle with `hr_pop`=1 while the read FIFO is empty has `host_ready`=0, which covers the wait for prefetched data. Popped words come out as mem[`rd_addr`+i] in order.
- R9: Each time 4 words of room free up in the read FIFO during a session, a new 4-word read burst is requested at the next sequential address.
- R10: After an `rflush` pulse, a read burst already in progress completes all 4 beats. The read FIFO is then emptied, so a pop sees `host_ready`=0, and no further read bursts are issued.
- R11: While `mem_req`=1 and `mem_gnt`=0, the next cycle keeps `mem_req`=1 with `mem_addr` and `mem_we` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_valid | input | 1 | Host presents a write word |
| hw_data | input | 32 | Host write word |
| hr_pop | input | 1 | Host takes a read word |
| hr_data | output | 32 | Head of the read FIFO |
| host_ready | output | 1 | 0 stalls the current host push or pop |
| wr_start | input | 1 | Latch `wr_addr` as the next write address |
| wr_addr | input | 32 | Word address for writes |
| rd_start | input | 1 | Open a sequential read session |
| rd_addr | input | 32 | Word address of the session |
| wflush | input | 1 | Pulse: drain the write remainder |
| rflush | input | 1 | Pulse: end the session and discard prefetched data |
| mem_req | output | 1 | Memory transfer requested |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Word address of the current beat |
| mem_wdata | output | 32 | Write data of the current beat |
| mem_gnt | input | 1 | Beat accepted this cycle |
| mem_rdata | input | 32 | Read data, valid in the granted cycle |

## Verification
The checks that run on every cycle cover the stall rules, the memory handshake and the FIFO bounds. `host_ready` must be 0 on a push into a full write FIFO and on a pop from an empty read FIFO. A held request must keep its address and direction until granted. A write beat must never drain an empty FIFO, and a read beat must never land in a full one. The bench scenarios are the only way to show the properties that play out over many cycles. These are: the 4-word threshold and flush-driven remainder for writes, the two back-to-back prefetch bursts and their refill after four pops, the address sequence, and a flush that lets a stalled burst finish before the data disappears.

// File: rtl/hbf_pkg.sv
package hbf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WBURST = 2'd1,
        ST_RBURST = 2'd2
    } dma_state_t;
endpackage

// File: rtl/hbf_fifo.sv
module hbf_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic [PW:0]   count,
    output logic          full,
    output logic          empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW:0]   wptr;
    logic [PW:0]   rptr;
    logic          do_push;
    logic          do_pop;

    assign count   = wptr - rptr;
    assign full    = (count == (PW+1)'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr[PW-1:0]];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr[PW-1:0]] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else if (clr) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
        end
    end
endmodule

// File: rtl/hbf_dma.sv
module hbf_dma
    import hbf_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DEPTH = 8,
    parameter int BURST = 4,
    localparam int CW   = $clog2(DEPTH) + 1,
    localparam int BW   = $clog2(BURST + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] wcount,
    input  logic [CW-1:0] rcount,
    input  logic          wflush,
    input  logic          rflush,
    input  logic          rd_start,
    input  logic [AW-1:0] rd_addr,
    input  logic          wr_start,
    input  logic [AW-1:0] wr_addr,
    input  logic          mem_gnt,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic          wpop,
    output logic          rpush,
    output logic          rclr
);
    dma_state_t    state, state_n;
    logic [BW-1:0] beat;
    logic [BW-1:0] blen;
    logic [AW-1:0] cur_addr;
    logic [AW-1:0] wbase;
    logic [AW-1:0] rbase;
    logic          active;
    logic          pend_r;
    logic          pend_act;
    logic [AW-1:0] pend_addr;
    logic          wfl_pend;

    logic          granted;
    logic          last;
    logic [CW-1:0] wcnt_eff;
    logic [CW-1:0] rcnt_eff;
    logic          wr_go;
    logic          rd_go;
    logic [BW-1:0] wlen_new;
    logic          start_w;
    logic          start_r;

    // outputs of the machine
    always_comb begin
        mem_req  = (state != ST_IDLE);
        mem_we   = (state == ST_WBURST);
        mem_addr = cur_addr + AW'(beat);
        wpop     = (state == ST_WBURST) && mem_gnt;
        rpush    = (state == ST_RBURST) && mem_gnt;
        rclr     = pend_r && (state != ST_RBURST);
        granted  = mem_req && mem_gnt;
        last     = granted && (beat == blen - BW'(1));
    end

    // burst eligibility, counting the beat moving in this cycle
    always_comb begin
        wcnt_eff = wcount - CW'(wpop);
        rcnt_eff = rcount + CW'(rpush);
        wr_go    = (wcnt_eff >= CW'(BURST)) ||
                   ((wfl_pend || wflush) && (wcnt_eff != '0));
        rd_go    = active && !pend_r && !rflush && !rd_start &&
                   ((CW'(DEPTH) - rcnt_eff) >= CW'(BURST));
        wlen_new = (wcnt_eff >= CW'(BURST)) ? BW'(BURST) : BW'(wcnt_eff);
    end

    // next state
    always_comb begin
        state_n = state;
        start_w = 1'b0;
        start_r = 1'b0;
        unique case (state)
            ST_IDLE, ST_WBURST, ST_RBURST: begin
                if ((state == ST_IDLE) || last) begin
                    if (wr_go) begin
                        state_n = ST_WBURST;
                        start_w = 1'b1;
                    end else if (rd_go) begin
                        state_n = ST_RBURST;
                        start_r = 1'b1;
                    end else begin
                        state_n = ST_IDLE;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // burst bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat      <= '0;
            blen      <= BW'(BURST);
            cur_addr  <= '0;
            wbase     <= '0;
            rbase     <= '0;
            active    <= 1'b0;
            pend_r    <= 1'b0;
            pend_act  <= 1'b0;
            pend_addr <= '0;
            wfl_pend  <= 1'b0;
        end else begin
            if (start_w || start_r || last) begin
                beat <= '0;
            end else if (granted) begin
                beat <= beat + 1'b1;
            end

            if (start_w) begin
                blen     <= wlen_new;
                cur_addr <= wbase;
            end else if (start_r) begin
                blen     <= BW'(BURST);
                cur_addr <= rbase;
            end

            if (wr_start) begin
                wbase <= wr_addr;
            end else if (start_w) begin
                wbase <= wbase + AW'(wlen_new);
            end

            if (rclr) begin
                rbase  <= pend_addr;
                active <= pend_act;
            end else if (start_r) begin
                rbase <= rbase + AW'(BURST);
            end

            if (rflush) begin
                pend_r   <= 1'b1;
                pend_act <= 1'b0;
            end else if (rd_start) begin
                pend_r    <= 1'b1;
                pend_act  <= 1'b1;
                pend_addr <= rd_addr;
            end else if (rclr) begin
                pend_r <= 1'b0;
            end

            if (wflush) begin
                wfl_pend <= 1'b1;
            end else if ((wcount == '0) && (state != ST_WBURST)) begin
                wfl_pend <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/host_burst_fifos.sv
module host_burst_fifos #(
    parameter int DW    = 32,
    parameter int AW    = 32,
    parameter int DEPTH = 8,
    parameter int BURST = 4,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hw_valid,
    input  logic [DW-1:0] hw_data,
    input  logic          hr_pop,
    output logic [DW-1:0] hr_data,
    output logic          host_ready,
    input  logic          wr_start,
    input  logic [AW-1:0] wr_addr,
    input  logic          rd_start,
    input  logic [AW-1:0] rd_addr,
    input  logic          wflush,
    input  logic          rflush,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_gnt,
    input  logic [DW-1:0] mem_rdata
);
    logic [CW-1:0] wcount;
    logic [CW-1:0] rcount;
    logic          wfull;
    logic          wempty;
    logic          rfull;
    logic          rempty;
    logic          wpop;
    logic          rpush;
    logic          rclr;

    assign host_ready = !((hw_valid && wfull) || (hr_pop && rempty));

    hbf_fifo #(.DW(DW), .DEPTH(DEPTH)) i_wfifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (1'b0),
        .push  (hw_valid),
        .din   (hw_data),
        .pop   (wpop),
        .dout  (mem_wdata),
        .count (wcount),
        .full  (wfull),
        .empty (wempty)
    );

    hbf_fifo #(.DW(DW), .DEPTH(DEPTH)) i_rfifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rclr),
        .push  (rpush),
        .din   (mem_rdata),
        .pop   (hr_pop),
        .dout  (hr_data),
        .count (rcount),
        .full  (rfull),
        .empty (rempty)
    );

    hbf_dma #(.AW(AW), .DEPTH(DEPTH), .BURST(BURST)) i_dma (
        .clk      (clk),
        .rst_n    (rst_n),
        .wcount   (wcount),
        .rcount   (rcount),
        .wflush   (wflush),
        .rflush   (rflush),
        .rd_start (rd_start),
        .rd_addr  (rd_addr),
        .wr_start (wr_start),
        .wr_addr  (wr_addr),
        .mem_gnt  (mem_gnt),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .wpop     (wpop),
        .rpush    (rpush),
        .rclr     (rclr)
    );
endmodule

// File: rtl/host_burst_fifos_chk.sv
module host_burst_fifos_chk #(
    parameter int AW    = 32,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hw_valid,
    input logic          hr_pop,
    input logic          host_ready,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_gnt,
    input logic [AW-1:0] mem_addr,
    input logic [CW-1:0] wcount,
    input logic [CW-1:0] rcount,
    input logic          wempty,
    input logic          rfull
);
    a_r4_full_stalls_push: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_valid && (wcount == CW'(DEPTH))) |-> !host_ready);

    a_r8_empty_stalls_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (hr_pop && (rcount == '0)) |-> !host_ready);

    a_r11_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r2_write_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !wempty);

    a_r6_read_has_room: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> !rfull);
endmodule

bind host_burst_fifos host_burst_fifos_chk #(.AW(AW), .DEPTH(DEPTH)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hw_valid   (hw_valid),
    .hr_pop     (hr_pop),
    .host_ready (host_ready),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_gnt    (mem_gnt),
    .mem_addr   (mem_addr),
    .wcount     (wcount),
    .rcount     (rcount),
    .wempty     (wempty),
    .rfull      (rfull)
);

// File: tb/test_host_burst_fifos.sv
module test_host_burst_fifos;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_valid = 1'b0;
    logic [31:0] hw_data = '0;
    logic        hr_pop = 1'b0;
    logic [31:0] hr_data;
    logic        host_ready;
    logic        wr_start = 1'b0;
    logic [31:0] wr_addr = '0;
    logic        rd_start = 1'b0;
    logic [31:0] rd_addr = '0;
    logic        wflush = 1'b0;
    logic        rflush = 1'b0;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_gnt = 1'b0;
    logic [31:0] mem_rdata;

    logic [31:0] mem [256];
    int          nchk = 0;
    int          nfail = 0;
    int          cyc = 0;
    int          gnt_mode = 0;
    int          gnt_tick = 0;
    int          wbeats = 0;
    int          rbeats = 0;
    int          rfirst = 0;
    int          rlast = 0;
    logic [31:0] wmodel_addr = '0;
    logic [31:0] rpf_addr = '0;
    logic [31:0] rexp_addr = '0;
    logic [31:0] exp_wa [$];
    logic [31:0] exp_wd [$];

    always #10 clk = ~clk;

    host_burst_fifos i_host_burst_fifos (
        .clk(clk), .rst_n(rst_n), .hw_valid(hw_valid), .hw_data(hw_data),
        .hr_pop(hr_pop), .hr_data(hr_data), .host_ready(host_ready),
        .wr_start(wr_start), .wr_addr(wr_addr), .rd_start(rd_start), .rd_addr(rd_addr),
        .wflush(wflush), .rflush(rflush), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return 32'h5A00_0000 + a * 32'h0001_0001;
    endfunction

    assign mem_rdata = mem[mem_addr[7:0]];

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = pat(32'(i));
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        gnt_tick = gnt_tick + 1;
        mem_gnt = (gnt_mode == 0) || ((gnt_mode == 2) && gnt_tick[0]);
    end

    // scoreboard monitor, samples after inputs settle and before the edge
    always @(negedge clk) begin
        #2;
        if (rst_n && mem_req && mem_gnt) begin
            if (mem_we) begin
                wbeats++;
                mem[mem_addr[7:0]] = mem_wdata;
                if (exp_wa.size() == 0) begin
                    check(1'b0, "R2 unexpected write beat", mem_addr, 32'hx);
                end else begin
                    logic [31:0] ea;
                    logic [31:0] ed;
                    ea = exp_wa.pop_front();
                    ed = exp_wd.pop_front();
                    check(mem_addr == ea, "R3 write address", mem_addr, ea);
                    check(mem_wdata == ed, "R2 write data order", mem_wdata, ed);
                end
            end else begin
                if (rbeats == 0) rfirst = cyc;
                rlast = cyc;
                rbeats++;
                check(mem_addr == rpf_addr, "R9 read burst address", mem_addr, rpf_addr);
                rpf_addr = rpf_addr + 1;
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_waddr(input logic [31:0] a);
        wr_start = 1'b1;
        wr_addr = a;
        wmodel_addr = a;
        @(negedge clk);
        wr_start = 1'b0;
    endtask

    task automatic host_write(input logic [31:0] d);
        exp_wa.push_back(wmodel_addr);
        exp_wd.push_back(d);
        wmodel_addr = wmodel_addr + 1;
        hw_valid = 1'b1;
        hw_data = d;
        forever begin
            #1;
            if (host_ready) begin
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        hw_valid = 1'b0;
    endtask

    task automatic host_read(input string req);
        hr_pop = 1'b1;
        forever begin
            #1;
            if (host_ready) begin
                check(hr_data == pat(rexp_addr), req, hr_data, pat(rexp_addr));
                rexp_addr = rexp_addr + 1;
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        hr_pop = 1'b0;
    endtask

    task automatic read_session(input logic [31:0] a);
        rd_start = 1'b1;
        rd_addr = a;
        rpf_addr = a;
        rexp_addr = a;
        @(negedge clk);
        rd_start = 1'b0;
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        report();
    end

    initial begin
        logic [31:0] held;
        int base;
        idle(5);
        rst_n = 1'b1;
        #1;
        check(host_ready == 1'b1, "R1 ready after reset", 32'(host_ready), 1);
        check(mem_req == 1'b0, "R1 no request after reset", 32'(mem_req), 0);
        @(negedge clk);

        // R2: threshold of four
        set_waddr(32'h80);
        for (int i = 0; i < 3; i++) host_write(32'h1000 + 32'(i));
        idle(10);
        check(wbeats == 0, "R2 no burst below four", 32'(wbeats), 0);
        host_write(32'h1003);
        idle(10);
        check(wbeats == 4, "R2 burst of four", 32'(wbeats), 4);

        // R3: next burst continues
        for (int i = 4; i < 8; i++) host_write(32'h1000 + 32'(i));
        idle(10);
        check(wbeats == 8, "R3 second burst", 32'(wbeats), 8);
        check(exp_wa.size() == 0, "R3 scoreboard drained", 32'(exp_wa.size()), 0);

        // R4 / R11: full FIFO with the memory stalled
        gnt_mode = 1;
        @(negedge clk);
        for (int i = 8; i < 16; i++) host_write(32'h2000 + 32'(i));
        held = mem_addr;
        hw_valid = 1'b1;
        hw_data = 32'h2010;
        #1;
        check(host_ready == 1'b0, "R4 push into full stalls", 32'(host_ready), 0);
        idle(3);
        #1;
        check(host_ready == 1'b0, "R4 still stalled", 32'(host_ready), 0);
        check(mem_req == 1'b1, "R11 request held", 32'(mem_req), 1);
        check(mem_addr == held, "R11 address held", mem_addr, held);
        hw_valid = 1'b0;
        gnt_mode = 0;
        @(negedge clk);
        host_write(32'h2010);
        idle(20);
        check(wbeats == 16, "R4 stalled word kept", 32'(wbeats), 16);

        // R5: flush drains the remainder
        host_write(32'h3000);
        idle(10);
        check(wbeats == 16, "R5 remainder held without flush", 32'(wbeats), 16);
        wflush = 1'b1;
        @(negedge clk);
        wflush = 1'b0;
        idle(10);
        check(wbeats == 18, "R5 remainder written", 32'(wbeats), 18);
        check(exp_wa.size() == 0, "R5 scoreboard drained", 32'(exp_wa.size()), 0);

        // R6 / R7 / R8: prefetch
        read_session(32'h10);
        hr_pop = 1'b1;
        #1;
        check(host_ready == 1'b0, "R8 pop while empty stalls", 32'(host_ready), 0);
        hr_pop = 1'b0;
        @(negedge clk);
        idle(20);
        check(rbeats == 8, "R6 two bursts prefetched", 32'(rbeats), 8);
        check((rlast - rfirst) == 7, "R7 bursts back to back", 32'(rlast - rfirst), 7);

        // R9: refill after four pops
        for (int i = 0; i < 4; i++) host_read("R8 read data");
        idle(15);
        check(rbeats == 12, "R9 refill burst", 32'(rbeats), 12);
        for (int i = 0; i < 8; i++) host_read("R9 read data");
        idle(15);
        check(rbeats == 20, "R9 refill bursts", 32'(rbeats), 20);

        // R10: flush waits for an in-flight burst
        gnt_mode = 2;
        base = rbeats;
        read_session(32'h40);
        forever begin
            @(negedge clk);
            #3;
            if (rbeats > base) break;
        end
        @(negedge clk);
        rflush = 1'b1;
        @(negedge clk);
        rflush = 1'b0;
        idle(30);
        check((rbeats - base) == 4, "R10 in-flight burst completed", 32'(rbeats - base), 4);
        check(mem_req == 1'b0, "R10 no further bursts", 32'(mem_req), 0);
        hr_pop = 1'b1;
        #1;
        check(host_ready == 1'b0, "R10 read FIFO discarded", 32'(host_ready), 0);
        hr_pop = 1'b0;
        @(negedge clk);
        idle(10);
        check((rbeats - base) == 4, "R10 session ended", 32'(rbeats - base), 4);

        report();
    end
endmodule